// File: doc/BRIEF.md
# Virtual Address Segment Privilege Checker

This block sits in front of an address translation unit for a 32-bit address space that is split into five fixed windows by the top address bits. Each request carries a virtual address, the privilege level of the code making the access, and an error-level flag. The block returns one of three verdicts. The address may be legal and unmapped, in which case the physical address comes from a fixed offset. It may be legal and mapped, in which case the caller must consult the translation buffer. Otherwise it is an illegal access that must raise an address error.

The user window sits at the bottom half of the space and is open to every privilege level. Two cached and uncached kernel windows are translated by subtracting their base, and only kernel code may use them. A supervisor window and a top kernel window are both mapped. The supervisor window admits supervisor and kernel code. The top kernel window admits kernel code only. When the error-level flag is set, the user window bypasses mapping and passes the virtual address through unchanged. This lets recovery code run with translation disabled.

The verdict, the physical address and a read/write grant are registered. They appear one clock after a request strobe.

Top module: `vaSegGuard`

## Requirements
- R1: With the error-level flag clear, an address in 0x00000000..0x7FFFFFFF gives result code 2'b01 (mapped), physical address 0 and read/write grants 0 in every privilege level.
- R2: With the error-level flag set, an address in 0x00000000..0x7FFFFFFF gives result code 2'b00 (direct), physical address equal to the virtual address, and both grants set, in every privilege level.
- R3: In kernel level (mode 2'b00), an address in 0x80000000..0x9FFFFFFF gives code 2'b00, physical address equal to the address minus 0x80000000, and both grants set.
- R4: In kernel level, an address in 0xA0000000..0xBFFFFFFF gives code 2'b00, physical address equal to the address minus 0xA0000000, and both grants set.
- R5: An address in 0x80000000..0xBFFFFFFF from supervisor (2'b01) or user (2'b10) level gives code 2'b10 (bad).
- R6: An address in 0xC0000000..0xDFFFFFFF gives code 2'b01 in kernel or supervisor level and code 2'b10 in user level.
- R7: An address in 0xE0000000..0xFFFFFFFF gives code 2'b01 in kernel level and code 2'b10 in every other level.
- R8: A code 2'b10 result drives the physical address and both grants to zero.
- R9: Outputs update on the clock edge that samples the request strobe high. The response-valid flag is high for exactly the cycles that follow a strobed cycle. In a cycle with no strobe, the code, address and grants keep their values.
- R10: After reset, response-valid is 0, the code is 2'b00, and the physical address and grants are 0.
- R11: Mode 2'b11 is treated as user level. The error-level flag has no effect on addresses at or above 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Virtual address |
| reqMode | input | 2 | Privilege level: 00 kernel, 01 supervisor, 10 user, 11 user |
| reqErl | input | 1 | Error-level flag |
| rspValid | output | 1 | Response present this cycle |
| rspCode | output | 2 | 00 direct, 01 mapped, 10 bad |
| rspPhys | output | 32 | Physical address, nonzero only for direct results |
| rspRead | output | 1 | Read grant for direct results |
| rspWrite | output | 1 | Write grant for direct results |

## Verification
A new request can be captured in the same cycle that the previous verdict is being presented. The dangerous pair is a direct translation followed at once by a bad address, because the zero-forcing of the address and grants must override the nonzero values still held in the output registers. The bench drives such pairs on consecutive cycles with the strobe held high. It checks each verdict on the cycle after its own capture. It also checks that a gap cycle with the strobe low leaves the last verdict untouched while response-valid drops.

// File: rtl/vaSegPkg.sv
package vaSegPkg;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUPV = 2'b01,
    MODE_USER = 2'b10,
    MODE_RSVD = 2'b11
  } privMode_e;

  typedef enum logic [1:0] {
    RES_DIRECT = 2'b00,
    RES_MAP    = 2'b01,
    RES_BAD    = 2'b10
  } resCode_e;

  typedef enum logic [2:0] {
    SEG_USER,
    SEG_KUNC0,
    SEG_KUNC1,
    SEG_SUPV,
    SEG_KTOP
  } segId_e;

  typedef enum logic [1:0] {
    OFS_NONE,
    OFS_WIN0,
    OFS_WIN1
  } offSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     capture;
    resCode_e code;
    offSel_e  offSel;
    logic     grant;
  } ctrlStrobe_t;

endpackage

// File: rtl/vaSegCtrl.sv
module vaSegCtrl
  import vaSegPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqMode,
  input  logic              reqErl,
  output ctrlStrobe_t       strobe
);

  localparam int SEL_W = 3;

  logic [SEL_W-1:0] topBits;
  segId_e           seg;
  privMode_e        mode;
  logic             isKern;
  logic             isSupOrKern;

  assign topBits     = reqAddr[ADDR_W-1 -: SEL_W];
  assign mode        = privMode_e'(reqMode);
  assign isKern      = (mode == MODE_KERN);
  assign isSupOrKern = (mode == MODE_KERN) || (mode == MODE_SUPV);

  always_comb begin
    unique casez (topBits)
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_KUNC0;
      3'b101:  seg = SEG_KUNC1;
      3'b110:  seg = SEG_SUPV;
      default: seg = SEG_KTOP;
    endcase
  end

  always_comb begin
    strobe.capture = reqValid;
    strobe.code    = RES_BAD;
    strobe.offSel  = OFS_NONE;
    strobe.grant   = 1'b0;
    unique case (seg)
      SEG_USER: begin
        if (reqErl) begin
          strobe.code  = RES_DIRECT;
          strobe.grant = 1'b1;
        end else begin
          strobe.code  = RES_MAP;
        end
      end
      SEG_KUNC0: begin
        if (isKern) begin
          strobe.code   = RES_DIRECT;
          strobe.offSel = OFS_WIN0;
          strobe.grant  = 1'b1;
        end
      end
      SEG_KUNC1: begin
        if (isKern) begin
          strobe.code   = RES_DIRECT;
          strobe.offSel = OFS_WIN1;
          strobe.grant  = 1'b1;
        end
      end
      SEG_SUPV: begin
        if (isSupOrKern) strobe.code = RES_MAP;
      end
      default: begin
        if (isKern) strobe.code = RES_MAP;
      end
    endcase
  end

  // R5: unmapped kernel windows refused outside kernel level
  a_r5_kwin_kernel_only: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[ADDR_W-1 -: 2] == 2'b10 && reqMode != 2'b00)
      |-> (strobe.code == RES_BAD && !strobe.grant));

  // R7: top window only for kernel level
  a_r7_top_kernel_only: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[ADDR_W-1 -: 3] == 3'b111 && reqMode != 2'b00)
      |-> strobe.code == RES_BAD);

  // R11: user-like levels never get a mapped verdict above the user window
  a_r11_user_high_bad: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[ADDR_W-1] && reqMode[1])
      |-> strobe.code == RES_BAD);

endmodule

// File: rtl/vaSegPath.sv
module vaSegPath
  import vaSegPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspRead,
  output logic              rspWrite
);

  localparam logic [ADDR_W-1:0] WIN0_BASE = {3'b100, {(ADDR_W-3){1'b0}}};
  localparam logic [ADDR_W-1:0] WIN1_BASE = {3'b101, {(ADDR_W-3){1'b0}}};

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] physNext;
  logic              isDirect;

  always_comb begin
    unique case (strobe.offSel)
      OFS_WIN0: offset = WIN0_BASE;
      OFS_WIN1: offset = WIN1_BASE;
      default:  offset = '0;
    endcase
  end

  assign isDirect = (strobe.code == RES_DIRECT);
  assign physNext = isDirect ? (reqAddr - offset) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= RES_DIRECT;
      rspPhys  <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) begin
        rspCode  <= strobe.code;
        rspPhys  <= physNext;
        rspRead  <= strobe.grant && isDirect;
        rspWrite <= strobe.grant && isDirect;
      end
    end
  end

  // R8: bad verdict carries no address and no grant
  a_r8_bad_zeroed: assert property (@(posedge clk) disable iff (!rstN)
    (rspCode == RES_BAD) |-> (rspPhys == '0 && !rspRead && !rspWrite));

  // R9: a strobed cycle produces a response next cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValid);

  // R9: without a strobe the verdict holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(rspCode) && $stable(rspPhys) && !rspValid));

  // R2: direct results land in the low half with full grant
  a_r2_direct_low: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == RES_DIRECT) |-> (!rspPhys[ADDR_W-1] && rspRead && rspWrite));

endmodule

// File: rtl/vaSegGuard.sv
module vaSegGuard
  import vaSegPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqMode,
  input  logic              reqErl,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspRead,
  output logic              rspWrite
);

  ctrlStrobe_t strobe;

  vaSegCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqMode  (reqMode),
    .reqErl   (reqErl),
    .strobe   (strobe)
  );

  vaSegPath #(.ADDR_W(ADDR_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspCode  (rspCode),
    .rspPhys  (rspPhys),
    .rspRead  (rspRead),
    .rspWrite (rspWrite)
  );

endmodule

// File: tb/vaSegGuard_tb.sv
module vaSegGuard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqMode = 2'b00;
  logic        reqErl = 1'b0;
  logic        rspValid;
  logic [1:0]  rspCode;
  logic [31:0] rspPhys;
  logic        rspRead;
  logic        rspWrite;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vaSegGuard u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqMode(reqMode), .reqErl(reqErl), .rspValid(rspValid), .rspCode(rspCode),
    .rspPhys(rspPhys), .rspRead(rspRead), .rspWrite(rspWrite)
  );

  // Model written from the requirements
  task automatic model(input logic [31:0] a, input logic [1:0] m, input logic e,
                       output logic [1:0] c, output logic [31:0] p, output logic g,
                       output string tag);
    bit kern = (m == 2'b00);
    bit supk = (m == 2'b00) || (m == 2'b01);
    c = 2'b10; p = '0; g = 1'b0;
    if (a <= 32'h7FFFFFFF) begin
      if (e) begin c = 2'b00; p = a; g = 1'b1; tag = "R2"; end
      else begin c = 2'b01; tag = "R1"; end
    end else if (a <= 32'h9FFFFFFF) begin
      if (kern) begin c = 2'b00; p = a - 32'h80000000; g = 1'b1; tag = "R3"; end
      else tag = "R5";
    end else if (a <= 32'hBFFFFFFF) begin
      if (kern) begin c = 2'b00; p = a - 32'hA0000000; g = 1'b1; tag = "R4"; end
      else tag = "R5";
    end else if (a <= 32'hDFFFFFFF) begin
      if (supk) c = 2'b01;
      tag = "R6";
    end else begin
      if (kern) c = 2'b01;
      tag = "R7";
    end
    if (m == 2'b11) tag = {tag, "/R11"};
    if (c == 2'b10) tag = {tag, "/R8"};
  endtask

  task automatic checkOut(input string tag, input logic expV, input logic [1:0] c,
                          input logic [31:0] p, input logic g);
    nChecks++;
    if (rspValid !== expV || rspCode !== c || rspPhys !== p ||
        rspRead !== g || rspWrite !== g) begin
      nFails++;
      $display("FAIL %s: got v=%b code=%b phys=%h r=%b w=%b, expected v=%b code=%b phys=%h r=%b w=%b",
               tag, rspValid, rspCode, rspPhys, rspRead, rspWrite, expV, c, p, g, g);
    end
  endtask

  task automatic applyOne(input logic [31:0] a, input logic [1:0] m, input logic e);
    logic [1:0] c; logic [31:0] p; logic g; string tag;
    model(a, m, e, c, p, g, tag);
    @(negedge clk);
    reqAddr = a; reqMode = m; reqErl = e; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut(tag, 1'b1, c, p, g);
  endtask

  task automatic testReset();
    checkOut("R10 reset", 1'b0, 2'b00, 32'h0, 1'b0);
  endtask

  task automatic testBoundaries();
    logic [31:0] addrs [12] = '{32'h00000000, 32'h12345678, 32'h7FFFFFFF,
                                32'h80000000, 32'h9FFFFFFF, 32'hA0000000,
                                32'hBFFFFFFF, 32'hC0000000, 32'hDFFFFFFF,
                                32'hE0000000, 32'hF0001234, 32'hFFFFFFFF};
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 12; i++)
          applyOne(addrs[i], 2'(m), 1'(e));
  endtask

  // R9: gap cycle holds verdict, valid drops
  task automatic testHold();
    applyOne(32'h80001000, 2'b00, 1'b0);
    @(negedge clk);
    reqAddr = 32'hE0000000; reqMode = 2'b10;
    @(negedge clk);
    checkOut("R9 hold", 1'b0, 2'b00, 32'h00001000, 1'b1);
  endtask

  // R8/R9: direct verdict immediately followed by a bad one
  task automatic testBackToBack();
    @(negedge clk);
    reqAddr = 32'hA0ABCDEF; reqMode = 2'b00; reqErl = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    checkOut("R4 burst first", 1'b1, 2'b00, 32'h00ABCDEF, 1'b1);
    reqAddr = 32'h9FFF0000; reqMode = 2'b01;
    @(negedge clk);
    checkOut("R8 burst second", 1'b1, 2'b10, 32'h0, 1'b0);
    reqAddr = 32'h7000ABCD; reqMode = 2'b10;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut("R2 burst third", 1'b1, 2'b00, 32'h7000ABCD, 1'b1);
    @(negedge clk);
    checkOut("R9 burst end", 1'b0, 2'b00, 32'h7000ABCD, 1'b1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBoundaries();
    testHold();
    testBackToBack();
    finish();
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish();
  end

endmodule